// File: doc/BRIEF.md
# ISA I/O Slave Port with 16-bit Width Probe

This block is the slave side of an ISA peripheral's I/O port. It compares the 10-bit I/O address with a programmed base window. The address-enable qualifier takes part in the compare. The active-low read and write strobes are brought into the block clock. Each qualified strobe becomes one request on an internal register port. The block keeps the channel-ready line pulled low until the register side answers. After that it returns read data on the bus, or it reports that the write data has been taken.

The 16-bit capability pin is open-drain and works in both directions. After reset the block only listens on it. The block allows 16-bit I/O only after it has seen the pin high at least once. A board that grounds the pin therefore keeps the port in 8-bit mode for good. In 8-bit mode the port moves one byte per access, and address bit 0 selects the lane. In 16-bit mode the port pulls the pin low for every address in its window, whatever the strobes are doing, and it moves whole words.

The register port is a valid/ready request channel with a one-beat response. The request fields must stay unchanged while `reg_req_valid` is high and `reg_req_ready` is low. The response channel cannot push back. The register side asserts `reg_rsp_valid` for one cycle per accepted request, and it does so for writes as well as reads.

Top module: `isa_io_slave`

## Requirements
- R1: An access is decoded only when `isa_aen` is 0 and `isa_addr[9:5]` equals `cfg_base[9:5]`. Any other access creates no register request, leaves `chrdy_pull_low` at 0 and leaves `isa_data_oe` at 0.
- R2: Once 16-bit mode is enabled, `iocs16_pull_low` is 1 whenever the address is decoded, with both strobes high. It is 0 when `isa_aen` is 1 or the address is outside the window.
- R3: 16-bit mode is disabled after reset. It becomes enabled once `iocs16_in` has been 1 for at least one clock sample (after a two-flop synchroniser), and it stays enabled until reset. While the mode is disabled, `iocs16_pull_low` stays 0.
- R4: Each falling edge of `isa_ior_n` or `isa_iow_n` during a decoded access produces exactly one accepted register request. `reg_req_write` is 0 for a read and 1 for a write.
- R5: `reg_req_offset` is `isa_addr[4:1]`. In 16-bit mode `reg_req_be` is 2'b11 and `reg_req_wdata` is `isa_data_in`. In 8-bit mode `reg_req_be` is 2'b01 when `isa_addr[0]`=0 and 2'b10 when it is 1, and `reg_req_wdata` carries `isa_data_in[7:0]` on both byte lanes.
- R6: For a 16-bit read, `isa_data_out` is the full response word. For an 8-bit read, `isa_data_out[7:0]` is the response byte selected by `isa_addr[0]` (0 selects the low byte, 1 the high byte), and `isa_data_out[15:8]` is 0.
- R7: During a decoded access, `chrdy_pull_low` is 1 from the time the strobe goes low until the response has arrived. After the response it is 0, and it stays 0 while the strobe is held.
- R8: `isa_data_oe` is 1 only during a decoded read whose response has arrived, while `isa_ior_n` is still low.
- R9: While `reg_req_valid` is 1 and `reg_req_ready` is 0, the request stays valid and its fields do not change.
- R10: In reset and directly after it, `reg_req_valid`, `chrdy_pull_low`, `iocs16_pull_low` and `isa_data_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 10 | Programmed I/O base; upper bits define the window |
| isa_addr | input | 10 | ISA I/O address |
| isa_aen | input | 1 | Address enable; 0 qualifies an I/O slave access |
| isa_ior_n | input | 1 | I/O read strobe, active low |
| isa_iow_n | input | 1 | I/O write strobe, active low |
| isa_data_in | input | 16 | Data bus as seen by the pads |
| isa_data_out | output | 16 | Read data toward the pads |
| isa_data_oe | output | 1 | Data pad drive enable |
| iocs16_in | input | 1 | Sensed level of the 16-bit capability pin |
| iocs16_pull_low | output | 1 | Pull the 16-bit capability pin low |
| chrdy_pull_low | output | 1 | Pull the channel-ready line low (wait) |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 for write, 0 for read |
| reg_req_offset | output | 4 | Word offset inside the window |
| reg_req_be | output | 2 | Byte enables |
| reg_req_wdata | output | 16 | Write data |
| reg_rsp_valid | input | 1 | One-cycle completion of the accepted request |
| reg_rsp_rdata | input | 16 | Read data, valid with the response |

## Verification
The access path is tested with byte writes to the even and the odd address, and with byte reads of both. These show whether the lane select and the byte enables follow address bit 0. The same path is then tested with word accesses after the width probe, which separates the 8-bit lane handling from the full-word path. Accesses that carry the address enable, or an address outside the window, check that the decoder itself rejects traffic, so that rejection does not depend on a strobe arriving late. A read with a delayed ready and a slow response checks that the wait line stays low for the whole stall and that the request fields stay fixed while the request waits.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } slv_state_e;

  typedef struct packed {
    logic              write;
    logic              wide;
    logic              hi_lane;
    logic [LANES-1:0]  be;
    logic [WORD_W-1:0] wdata;
  } slv_cmd_t;
endpackage

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
  parameter int ADDR_W = 10,
  parameter int WIN_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              aen,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] CMP_MASK = {{(ADDR_W-WIN_W){1'b1}}, {WIN_W{1'b0}}};

  // Upper address bits select the window; AEN high marks a DMA cycle.
  always_comb hit = !aen && (((addr ^ base) & CMP_MASK) == '0);
endmodule

// File: rtl/isa_strobe_sync.sv
module isa_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic high_s
);
  logic [STAGES:0] chain;

  // Reset to the idle (high) level so reset release makes no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], strobe_n};
  end

  always_comb begin
    high_s = chain[STAGES-1];
    fall   = chain[STAGES] && !chain[STAGES-1];
  end
endmodule

// File: rtl/isa_width_probe.sv
module isa_width_probe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic wide_en
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      wide_en <= 1'b0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], pin_in};
      // Sticky: one observed high level unlocks 16-bit I/O until reset.
      wide_en <= wide_en || sync_q[STAGES-1];
    end
  end
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave #(
  parameter int ADDR_W      = 10,
  parameter int WIN_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  cfg_base,
  input  logic [ADDR_W-1:0]                  isa_addr,
  input  logic                               isa_aen,
  input  logic                               isa_ior_n,
  input  logic                               isa_iow_n,
  input  logic [isa_io_pkg::WORD_W-1:0]      isa_data_in,
  output logic [isa_io_pkg::WORD_W-1:0]      isa_data_out,
  output logic                               isa_data_oe,
  input  logic                               iocs16_in,
  output logic                               iocs16_pull_low,
  output logic                               chrdy_pull_low,
  output logic                               reg_req_valid,
  input  logic                               reg_req_ready,
  output logic                               reg_req_write,
  output logic [WIN_W-2:0]                   reg_req_offset,
  output logic [isa_io_pkg::LANES-1:0]       reg_req_be,
  output logic [isa_io_pkg::WORD_W-1:0]      reg_req_wdata,
  input  logic                               reg_rsp_valid,
  input  logic [isa_io_pkg::WORD_W-1:0]      reg_rsp_rdata
);
  import isa_io_pkg::*;

  localparam int N_STROBES = 2;  // index 0: read, index 1: write

  logic                 hit_now;
  logic                 wide_en;
  logic [N_STROBES-1:0] strobe_raw_n;
  logic [N_STROBES-1:0] strobe_fall;
  logic [N_STROBES-1:0] strobe_high;

  slv_state_e           state;
  slv_cmd_t             cmd;
  logic [WIN_W-2:0]     cmd_off;
  logic [WORD_W-1:0]    rd_hold;
  logic [WORD_W-1:0]    rsp_lane;

  isa_addr_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
    .addr (isa_addr),
    .base (cfg_base),
    .aen  (isa_aen),
    .hit  (hit_now)
  );

  isa_width_probe #(.STAGES(SYNC_STAGES)) u_probe (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (iocs16_in),
    .wide_en (wide_en)
  );

  assign strobe_raw_n = {isa_iow_n, isa_ior_n};

  for (genvar g = 0; g < N_STROBES; g++) begin : g_strobe
    isa_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobe_raw_n[g]),
      .fall     (strobe_fall[g]),
      .high_s   (strobe_high[g])
    );
  end

  // Lane steering of the response for 8-bit reads.
  always_comb begin
    if (cmd.wide) rsp_lane = reg_rsp_rdata;
    else          rsp_lane = {{BYTE_W{1'b0}},
                              cmd.hi_lane ? reg_rsp_rdata[WORD_W-1:BYTE_W]
                                          : reg_rsp_rdata[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd     <= '0;
      cmd_off <= '0;
      rd_hold <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (hit_now && (strobe_fall != '0)) begin
            // A read edge wins if both strobes fall together.
            cmd.write   <= !strobe_fall[0];
            cmd.wide    <= wide_en;
            cmd.hi_lane <= isa_addr[0];
            cmd.be      <= wide_en ? 2'b11 : (isa_addr[0] ? 2'b10 : 2'b01);
            cmd.wdata   <= wide_en ? isa_data_in : {LANES{isa_data_in[BYTE_W-1:0]}};
            cmd_off     <= isa_addr[WIN_W-1:1];
            state       <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (reg_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (reg_rsp_valid) begin
            if (!cmd.write) rd_hold <= rsp_lane;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (&strobe_high) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req_valid  = (state == ST_REQ);
    reg_req_write  = cmd.write;
    reg_req_offset = cmd_off;
    reg_req_be     = cmd.be;
    reg_req_wdata  = cmd.wdata;

    // Pure address decode: no strobe term.
    iocs16_pull_low = hit_now && wide_en;

    // Wait is asserted straight from the raw strobe, ahead of the synchroniser.
    chrdy_pull_low = hit_now && (!isa_ior_n || !isa_iow_n) && (state != ST_DONE);

    isa_data_oe  = (state == ST_DONE) && !cmd.write && hit_now && !isa_ior_n;
    isa_data_out = rd_hold;
  end
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int WIN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iocs16_in,
  input logic             iocs16_pull_low,
  input logic             chrdy_pull_low,
  input logic             isa_data_oe,
  input logic             reg_req_valid,
  input logic             reg_req_ready,
  input logic             reg_req_write,
  input logic [WIN_W-2:0] reg_req_offset,
  input logic [1:0]       reg_req_be,
  input logic [15:0]      reg_req_wdata,
  input logic             reg_rsp_valid
);
  logic probe_seen;
  logic rsp_seen;

  // Independent record of the pin: set one cycle after a high sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_seen <= 1'b0;
      rsp_seen   <= 1'b0;
    end else begin
      if (iocs16_in) probe_seen <= 1'b1;
      if (reg_req_valid && reg_req_ready) rsp_seen <= 1'b0;
      else if (reg_rsp_valid)             rsp_seen <= 1'b1;
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=> reg_req_valid && $stable(reg_req_write)
      && $stable(reg_req_offset) && $stable(reg_req_be) && $stable(reg_req_wdata));

  p_no_wide_before_probe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iocs16_pull_low |-> probe_seen);

  p_narrow_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !probe_seen |-> $countones(reg_req_be) == 1);

  p_oe_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isa_data_oe |-> rsp_seen);

  p_ready_free_when_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    isa_data_oe |-> !chrdy_pull_low);
endmodule

bind isa_io_slave isa_io_slave_chk #(.WIN_W(WIN_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .iocs16_in       (iocs16_in),
  .iocs16_pull_low (iocs16_pull_low),
  .chrdy_pull_low  (chrdy_pull_low),
  .isa_data_oe     (isa_data_oe),
  .reg_req_valid   (reg_req_valid),
  .reg_req_ready   (reg_req_ready),
  .reg_req_write   (reg_req_write),
  .reg_req_offset  (reg_req_offset),
  .reg_req_be      (reg_req_be),
  .reg_req_wdata   (reg_req_wdata),
  .reg_rsp_valid   (reg_rsp_valid)
);

// File: tb/isa_io_slave_test.sv
module isa_io_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] BASE = 10'h300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_base = BASE;
  logic [9:0]  isa_addr = '0;
  logic        isa_aen = 1'b1;
  logic        isa_ior_n = 1'b1;
  logic        isa_iow_n = 1'b1;
  logic [15:0] isa_data_in = '0;
  logic [15:0] isa_data_out;
  logic        isa_data_oe;
  logic        iocs16_in = 1'b0;
  logic        iocs16_pull_low;
  logic        chrdy_pull_low;
  logic        reg_req_valid;
  logic        reg_req_ready;
  logic        reg_req_write;
  logic [3:0]  reg_req_offset;
  logic [1:0]  reg_req_be;
  logic [15:0] reg_req_wdata;
  logic        reg_rsp_valid = 1'b0;
  logic [15:0] reg_rsp_rdata = '0;

  int checks = 0;
  int fails  = 0;

  // Register-side model.
  logic [15:0] rmem [16];
  int          stall_cfg = 0;
  int          rsp_delay = 0;
  int          valid_cycles = 0;
  int          hs_count = 0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [3:0]  last_off;
  logic [1:0]  last_be;
  logic [15:0] last_wdata;
  logic        last_write;
  logic [3:0]  first_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_io_slave uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .isa_addr(isa_addr),
    .isa_aen(isa_aen), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
    .isa_data_in(isa_data_in), .isa_data_out(isa_data_out), .isa_data_oe(isa_data_oe),
    .iocs16_in(iocs16_in), .iocs16_pull_low(iocs16_pull_low),
    .chrdy_pull_low(chrdy_pull_low), .reg_req_valid(reg_req_valid),
    .reg_req_ready(reg_req_ready), .reg_req_write(reg_req_write),
    .reg_req_offset(reg_req_offset), .reg_req_be(reg_req_be),
    .reg_req_wdata(reg_req_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_rdata(reg_rsp_rdata)
  );

  assign reg_req_ready = reg_req_valid && (valid_cycles >= stall_cfg);

  always @(posedge clk) begin
    reg_rsp_valid <= 1'b0;
    if (!reg_req_valid) valid_cycles <= 0;
    else begin
      if (valid_cycles == 0) first_off <= reg_req_offset;
      valid_cycles <= valid_cycles + 1;
    end
    if (reg_req_valid && reg_req_ready) begin
      hs_count++;
      last_off   <= reg_req_offset;
      last_be    <= reg_req_be;
      last_wdata <= reg_req_wdata;
      last_write <= reg_req_write;
      if (reg_req_write) begin
        if (reg_req_be[0]) rmem[reg_req_offset][7:0]  <= reg_req_wdata[7:0];
        if (reg_req_be[1]) rmem[reg_req_offset][15:8] <= reg_req_wdata[15:8];
      end
      reg_rsp_rdata <= rmem[reg_req_offset];
      pend <= 1'b1;
      cnt  <= rsp_delay;
    end
    if (pend) begin
      if (cnt == 0) begin
        reg_rsp_valid <= 1'b1;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One ISA I/O cycle; returns data seen while the read strobe is held.
  task automatic io_cycle(input bit wr, input logic [9:0] a, input logic aen,
                          input logic [15:0] wd, output logic [15:0] rd,
                          output logic oe, output int low_cycles);
    @(negedge clk);
    isa_addr = a; isa_aen = aen; isa_data_in = wd;
    @(negedge clk);
    if (wr) isa_iow_n = 1'b0; else isa_ior_n = 1'b0;
    low_cycles = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!chrdy_pull_low) break;
      low_cycles++;
    end
    repeat (4) @(negedge clk);
    rd = isa_data_out; oe = isa_data_oe;
    chk(!chrdy_pull_low, "R7 ready stays released while strobe held", chrdy_pull_low, 0);
    isa_ior_n = 1'b1; isa_iow_n = 1'b1;
    repeat (5) @(negedge clk);
    isa_aen = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!reg_req_valid && !chrdy_pull_low && !iocs16_pull_low && !isa_data_oe,
        "R10 outputs idle in reset", {reg_req_valid, chrdy_pull_low, iocs16_pull_low, isa_data_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!reg_req_valid && !chrdy_pull_low && !iocs16_pull_low && !isa_data_oe,
        "R10 outputs idle after reset", {reg_req_valid, chrdy_pull_low, iocs16_pull_low, isa_data_oe}, 0);
  endtask

  task automatic t_narrow;
    logic [15:0] rd; logic oe; int lc; int h0;
    @(negedge clk); isa_addr = BASE + 10'd4; isa_aen = 1'b0; #1;
    chk(!iocs16_pull_low, "R3 no 16-bit drive before probe", iocs16_pull_low, 0);
    h0 = hs_count;
    io_cycle(1, BASE + 10'd4, 1'b0, 16'hEE5A, rd, oe, lc);
    chk(hs_count == h0 + 1 && last_write, "R4 one write request per strobe", hs_count - h0, 1);
    chk(last_be == 2'b01 && last_off == 4'd2, "R5 even byte lane and offset", {last_be, last_off}, {2'b01, 4'd2});
    chk(last_wdata == 16'h5A5A, "R5 narrow write data on both lanes", last_wdata, 16'h5A5A);
    io_cycle(1, BASE + 10'd5, 1'b0, 16'h77C3, rd, oe, lc);
    chk(last_be == 2'b10 && last_off == 4'd2, "R5 odd byte lane", {last_be, last_off}, {2'b10, 4'd2});
    h0 = hs_count;
    io_cycle(0, BASE + 10'd5, 1'b0, 16'h0, rd, oe, lc);
    chk(hs_count == h0 + 1 && !last_write, "R4 one read request per strobe", hs_count - h0, 1);
    chk(oe, "R8 data driven during decoded read", oe, 1);
    chk(rd == 16'h00C3, "R6 odd byte returned on low lane", rd, 16'h00C3);
    io_cycle(0, BASE + 10'd4, 1'b0, 16'h0, rd, oe, lc);
    chk(rd == 16'h005A, "R6 even byte returned on low lane", rd, 16'h005A);
    chk(!isa_data_oe, "R8 data released after strobe", isa_data_oe, 0);
  endtask

  task automatic t_probe;
    @(negedge clk); iocs16_in = 1'b1;
    repeat (3) @(negedge clk); iocs16_in = 1'b0;
    repeat (2) @(negedge clk);
    isa_addr = BASE + 10'd6; isa_aen = 1'b0; #1;
    chk(iocs16_pull_low, "R3 probe enables 16-bit, sticky", iocs16_pull_low, 1);
    chk(iocs16_pull_low && isa_ior_n && isa_iow_n, "R2 drive with strobes idle", iocs16_pull_low, 1);
    isa_aen = 1'b1; #1;
    chk(!iocs16_pull_low, "R2 no drive with aen high", iocs16_pull_low, 0);
    isa_aen = 1'b0; isa_addr = BASE ^ 10'h040; #1;
    chk(!iocs16_pull_low, "R2 no drive outside window", iocs16_pull_low, 0);
    isa_aen = 1'b1;
  endtask

  task automatic t_wide;
    logic [15:0] rd; logic oe; int lc;
    io_cycle(1, BASE + 10'd6, 1'b0, 16'hBEEF, rd, oe, lc);
    chk(last_be == 2'b11 && last_wdata == 16'hBEEF && last_off == 4'd3,
        "R5 wide write", {last_be, last_wdata}, {2'b11, 16'hBEEF});
    io_cycle(0, BASE + 10'd6, 1'b0, 16'h0, rd, oe, lc);
    chk(rd == 16'hBEEF, "R6 wide read word", rd, 16'hBEEF);
    io_cycle(0, BASE + 10'd4, 1'b0, 16'h0, rd, oe, lc);
    chk(rd == 16'hC35A, "R6 wide read of byte-written word", rd, 16'hC35A);
  endtask

  task automatic t_ignore;
    logic [15:0] rd; logic oe; int lc; int h0;
    h0 = hs_count;
    io_cycle(1, BASE + 10'd6, 1'b1, 16'h1111, rd, oe, lc);
    chk(hs_count == h0 && lc == 0, "R1 aen high write ignored", hs_count - h0, 0);
    io_cycle(1, BASE ^ 10'h080, 1'b0, 16'h2222, rd, oe, lc);
    chk(hs_count == h0 && lc == 0, "R1 out-of-window write ignored", hs_count - h0, 0);
    io_cycle(0, BASE + 10'd6, 1'b1, 16'h0, rd, oe, lc);
    chk(hs_count == h0 && !oe && lc == 0, "R1 aen high read not driven", {hs_count - h0, oe}, 0);
    io_cycle(0, BASE + 10'd6, 1'b0, 16'h0, rd, oe, lc);
    chk(rd == 16'hBEEF, "R1 register unchanged by ignored writes", rd, 16'hBEEF);
  endtask

  task automatic t_delay;
    logic [15:0] rd; logic oe; int lc; int h0;
    stall_cfg = 3; rsp_delay = 7; h0 = hs_count;
    io_cycle(0, BASE + 10'd4, 1'b0, 16'h0, rd, oe, lc);
    chk(lc >= 10, "R7 ready held low through stall", lc, 10);
    chk(rd == 16'hC35A && oe, "R7 data valid after release", rd, 16'hC35A);
    chk(hs_count == h0 + 1 && first_off == last_off, "R9 request held until ready",
        {first_off, last_off}, {last_off, last_off});
    stall_cfg = 0; rsp_delay = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rmem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset;
    t_narrow;
    t_probe;
    t_wide;
    t_ignore;
    t_delay;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule